// File: doc/BRIEF.md
# Sideband Message Bridge

This block lets software drive an internal sideband message network through a 32-bit register port. Three word-aligned registers sit on the port: a command register, a data register and a status register. A full-word write to the command register is the command itself. The written word supplies the opcode, the destination port, the address offset and four byte-qualifier bits, and the bridge turns it straight into one request on the network.

The data register serves both directions. Before a write-type command, software loads it with the payload, and the bridge sends its contents. When a read-type command completes, the bytes of the response selected by the qualifier bits are loaded into it. While a command is outstanding, the status register shows busy. During that time, further commands and data-register writes are refused, and a refused command sets a sticky overrun flag.

On the network side, a request is offered with valid/ready and held until it is accepted. A read-type request then waits for one response beat.

Top module: `sbBridge`

## Requirements
- R1: After reset, the data register, the status register and a command-register read all return 0, and `reqValid` is low.
- R2: A write to the command register (byte address 0x00) with `cfgByteEn` = 4'hF while not busy raises `reqValid` one cycle later. The request carries the word's bits 31:24 on `reqOpcode`, bits 23:16 on `reqPort`, bits 15:8 on `reqOffset` and bits 7:4 on `reqByteEn`; bit 4 qualifies data byte 0 and bit 7 qualifies byte 3.
- R3: A command-register write with any `cfgByteEn` other than 4'hF has no effect: no request is issued and the overrun flag is not set.
- R4: While `reqValid` is high and `reqReady` is low, `reqValid` and all request fields hold their values. The cycle after `reqReady` is sampled high, `reqValid` is low, so each accepted command produces exactly one request.
- R5: An opcode that is not in the read list is sent as write-type. `reqExpectResp` is 0, `reqData` equals the data register contents at launch, and busy clears in the cycle after the handshake.
- R6: The read-list opcodes (defaults 0x06 and 0x10) are sent with `reqExpectResp` = 1 and `reqData` = 0. Busy stays set after the handshake until `rspValid` arrives. At that edge, the data register bytes whose qualifier bit is 1 take the matching `rspData` bytes, and the other bytes keep their values.
- R7: Reads of the command register return 0. The data register is read at byte address 0x04. The status register at 0x08 returns busy in bit 0 and overrun in bit 1, with all other bits 0.
- R8: A full command-register write while busy is ignored and sets the overrun flag. The flag stays set until a status write with byte 0 enabled and data bit 1 set clears it; a status write with bit 1 clear leaves it set.
- R9: Data-register writes update only the bytes whose `cfgByteEn` bit is set, and they are ignored entirely while busy.
- R10: `rspValid` is ignored when no read response is awaited, including while a read request is still waiting for `reqReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgRdEn | input | 1 | Register read strobe |
| cfgAddr | input | ADDR_W | Register byte address |
| cfgByteEn | input | 4 | Write byte enables |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data (combinational, 0 when not reading) |
| reqValid | output | 1 | Request offered to network |
| reqReady | input | 1 | Network accepts request |
| reqOpcode | output | 8 | Request opcode |
| reqPort | output | 8 | Destination port |
| reqOffset | output | 8 | Address offset |
| reqByteEn | output | 4 | Byte qualifiers |
| reqExpectResp | output | 1 | Request is read-type |
| reqData | output | 32 | Payload |
| rspValid | input | 1 | Response beat valid |
| rspData | input | 32 | Response data |

## Verification
The assertions check the following on every cycle:
- a pending request holds and drops after acceptance;
- a new request only ever follows a full command write;
- a partial command write never leaves idle;
- the data register and the request fields are frozen while busy;
- the overrun flag is sticky;
- command reads return zero.

Only the bench's scenarios can show the following:
- that the field bit positions and the per-byte merge of read responses produce the right values across all qualifier patterns and opcode classes;
- that the payload matches what software loaded;
- that stray responses and refused writes leave the data register unchanged when it is read back.

// File: rtl/sbBridgePkg.sv
package sbBridgePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } bridgeState_e;

  // Strobes and status handed from the control FSM to the datapath
  typedef struct packed {
    logic launch;      // capture command fields this cycle
    logic isRead;      // current message is read-type
    logic busy;        // a message is outstanding
    logic loadRsp;     // response beat accepted this cycle
    logic setOverrun;  // refused command write this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/sbBridgeCtrl.sv
module sbBridgeCtrl
  import sbBridgePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h00,
  parameter int NUM_RD_OPS = 2,
  parameter logic [NUM_RD_OPS*8-1:0] RD_OPS = 16'h1006
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [7:0]        cmdOpcode,
  input  logic              reqReady,
  input  logic              rspValid,
  output logic              reqValid,
  output ctrlStrobes_t      strb
);

  bridgeState_e state, stateNext;
  logic rdQ;
  logic cmdHit;
  logic opcIsRead;
  logic [NUM_RD_OPS-1:0] rdHit;

  // Opcode classification against the parameterised read list
  for (genvar g = 0; g < NUM_RD_OPS; g++) begin : gRdOp
    assign rdHit[g] = (cmdOpcode == RD_OPS[g*8 +: 8]);
  end
  assign opcIsRead = |rdHit;

  assign cmdHit = cfgWrEn && (cfgAddr == CMD_ADDR) && (cfgByteEn == 4'hF);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (cmdHit) stateNext = ST_SEND;
      ST_SEND: if (reqReady) stateNext = rdQ ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (rspValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rdQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && cmdHit) rdQ <= opcIsRead;
    end
  end

  assign reqValid        = (state == ST_SEND);
  assign strb.busy       = (state != ST_IDLE);
  assign strb.launch     = cmdHit && (state == ST_IDLE);
  assign strb.setOverrun = cmdHit && (state != ST_IDLE);
  assign strb.loadRsp    = (state == ST_WAIT) && rspValid;
  assign strb.isRead     = rdQ;

  AST_PARTIAL_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cfgWrEn && cfgAddr == CMD_ADDR && cfgByteEn != 4'hF) |=> (state == ST_IDLE)); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid); // R4
  AST_ONE_MSG: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqValid); // R4
  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !rspValid) |=> strb.busy); // R6

endmodule

// File: rtl/sbBridgeDatapath.sv
module sbBridgeDatapath
  import sbBridgePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W/8-1:0] cfgByteEn,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [DATA_W-1:0] rspData,
  output logic [DATA_W-1:0] cfgRdData,
  output logic [7:0]        reqOpcode,
  output logic [7:0]        reqPort,
  output logic [7:0]        reqOffset,
  output logic [DATA_W/8-1:0] reqByteEn,
  output logic [DATA_W-1:0] reqData
);

  localparam int NUM_BYTES = DATA_W / 8;
  localparam int OPC_LSB = DATA_W - 8;
  localparam int PORT_LSB = DATA_W - 16;
  localparam int OFF_LSB = DATA_W - 24;
  localparam int BE_LSB = 4;

  logic [7:0] msgOpc, msgPort, msgOff;
  logic [NUM_BYTES-1:0] msgBe;
  logic [DATA_W-1:0] dataQ;
  logic overrunQ;
  logic dataWr, statWr, ovrClear;

  assign dataWr   = cfgWrEn && (cfgAddr == DATA_ADDR) && !strb.busy;
  assign statWr   = cfgWrEn && (cfgAddr == STAT_ADDR);
  assign ovrClear = statWr && cfgByteEn[0] && cfgWrData[1];

  // Command field capture at launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgOpc  <= '0;
      msgPort <= '0;
      msgOff  <= '0;
      msgBe   <= '0;
    end else if (strb.launch) begin
      msgOpc  <= cfgWrData[OPC_LSB +: 8];
      msgPort <= cfgWrData[PORT_LSB +: 8];
      msgOff  <= cfgWrData[OFF_LSB +: 8];
      msgBe   <= cfgWrData[BE_LSB +: NUM_BYTES];
    end
  end

  // Data register, one lane per byte
  for (genvar b = 0; b < NUM_BYTES; b++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ[b*8 +: 8] <= '0;
      end else if (strb.loadRsp && msgBe[b]) begin
        dataQ[b*8 +: 8] <= rspData[b*8 +: 8];
      end else if (dataWr && cfgByteEn[b]) begin
        dataQ[b*8 +: 8] <= cfgWrData[b*8 +: 8];
      end
    end
  end

  // Sticky overrun flag; setting wins over clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrunQ <= 1'b0;
    else if (strb.setOverrun) overrunQ <= 1'b1;
    else if (ovrClear) overrunQ <= 1'b0;
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgRdEn) begin
      if (cfgAddr == DATA_ADDR) cfgRdData = dataQ;
      else if (cfgAddr == STAT_ADDR) cfgRdData = {{(DATA_W-2){1'b0}}, overrunQ, strb.busy};
    end
  end

  assign reqOpcode = msgOpc;
  assign reqPort   = msgPort;
  assign reqOffset = msgOff;
  assign reqByteEn = msgBe;
  assign reqData   = strb.isRead ? '0 : dataQ;

  AST_DATA_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.loadRsp) |=> $stable(dataQ)); // R9
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable({msgOpc, msgPort, msgOff, msgBe})); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunQ && !ovrClear) |=> overrunQ); // R8
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgAddr == CMD_ADDR) |-> (cfgRdData == '0)); // R7

endmodule

// File: rtl/sbBridge.sv
module sbBridge
  import sbBridgePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h04,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h08,
  parameter int NUM_RD_OPS = 2,
  parameter logic [NUM_RD_OPS*8-1:0] RD_OPS = 16'h1006
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [3:0]        cfgByteEn,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [7:0]        reqOpcode,
  output logic [7:0]        reqPort,
  output logic [7:0]        reqOffset,
  output logic [3:0]        reqByteEn,
  output logic              reqExpectResp,
  output logic [31:0]       reqData,
  input  logic              rspValid,
  input  logic [31:0]       rspData
);

  ctrlStrobes_t strb;

  sbBridgeCtrl #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR),
    .NUM_RD_OPS(NUM_RD_OPS), .RD_OPS(RD_OPS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn),
    .cmdOpcode(cfgWrData[31:24]),
    .reqReady(reqReady), .rspValid(rspValid),
    .reqValid(reqValid), .strb(strb)
  );

  sbBridgeDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(32),
    .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .rspData(rspData),
    .cfgRdData(cfgRdData),
    .reqOpcode(reqOpcode), .reqPort(reqPort), .reqOffset(reqOffset),
    .reqByteEn(reqByteEn), .reqData(reqData)
  );

  assign reqExpectResp = strb.isRead;

  AST_LAUNCH_FROM_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(cfgWrEn && cfgAddr == CMD_ADDR && cfgByteEn == 4'hF)); // R2
  AST_OVR_ON_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && cfgWrEn && cfgAddr == CMD_ADDR && cfgByteEn == 4'hF) |=> !$rose(reqValid)); // R8

endmodule

// File: tb/sbBridge_tb.sv
`timescale 1ns/1ps
module sbBridge_tb_top;

  localparam logic [7:0] A_CMD  = 8'h00;
  localparam logic [7:0] A_DATA = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgRdEn = 0;
  logic [7:0] cfgAddr = '0;
  logic [3:0] cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic reqValid, reqReady = 0, reqExpectResp;
  logic [7:0] reqOpcode, reqPort, reqOffset;
  logic [3:0] reqByteEn;
  logic [31:0] reqData;
  logic rspValid = 0;
  logic [31:0] rspData = '0;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sbBridge dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqReady(reqReady),
    .reqOpcode(reqOpcode), .reqPort(reqPort), .reqOffset(reqOffset),
    .reqByteEn(reqByteEn), .reqExpectResp(reqExpectResp), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = a; cfgWrData = d; cfgByteEn = be;
    @(negedge clk);
    cfgWrEn = 0; cfgByteEn = '0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgRdEn = 1; cfgAddr = a;
    #1 d = cfgRdData;
    cfgRdEn = 0;
  endtask

  task automatic handshake();
    reqReady = 1;
    @(negedge clk);
    reqReady = 0;
  endtask

  task automatic respond(input logic [31:0] d);
    @(negedge clk);
    rspValid = 1; rspData = d;
    @(negedge clk);
    rspValid = 0;
  endtask

  function automatic logic [31:0] beMask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  logic [7:0] opcList [6] = '{8'h06, 8'h10, 8'h07, 8'h11, 8'h3C, 8'hFF};

  initial begin
    logic [31:0] rd, pay, rsp, word, held;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    chk("R1 reqValid", {31'b0, reqValid}, 32'h0);
    cfgRead(A_DATA, rd); chk("R1 data", rd, 32'h0);
    cfgRead(A_STAT, rd); chk("R1 status", rd, 32'h0);
    cfgRead(A_CMD, rd);  chk("R1 cmd read", rd, 32'h0);

    // R3 partial command writes
    for (int be = 0; be < 15; be++) begin
      cfgWrite(A_CMD, 32'h07AA5540, be[3:0]);
      chk("R3 no launch", {31'b0, reqValid}, 32'h0);
      cfgRead(A_STAT, rd); chk("R3 no busy/overrun", rd, 32'h0);
    end

    // R9 byte-enabled data writes while idle
    cfgWrite(A_DATA, 32'h00000000, 4'hF);
    for (int be = 0; be < 16; be++) begin
      cfgWrite(A_DATA, 32'h11111111 * (be + 1), be[3:0]);
      held = (32'h11111111 * (be + 1)) & beMask(be[3:0]);
      cfgRead(A_DATA, rd); chk("R9 byte write", rd, held);
      cfgWrite(A_DATA, 32'h0, 4'hF);
    end

    // Main sweep: opcode classes x all qualifier patterns
    for (int i = 0; i < 96; i++) begin
      logic [7:0] opc;
      logic [3:0] be;
      logic isRd;
      opc = opcList[i % 6];
      be = 4'(i / 6);
      isRd = (opc == 8'h06) || (opc == 8'h10);
      pay = 32'hA5000000 ^ (i * 32'h01030507);
      rsp = ~pay ^ 32'(i);
      word = {opc, 8'(8'h40 + i), 8'(i * 4), be, 4'h0};
      cfgWrite(A_DATA, pay, 4'hF);
      cfgWrite(A_CMD, word, 4'hF);
      chk("R2 valid", {31'b0, reqValid}, 32'h1);
      chk("R2 opcode", {24'b0, reqOpcode}, {24'b0, opc});
      chk("R2 port", {24'b0, reqPort}, {24'b0, word[23:16]});
      chk("R2 offset", {24'b0, reqOffset}, {24'b0, word[15:8]});
      chk("R2 byteen", {28'b0, reqByteEn}, {28'b0, be});
      chk(isRd ? "R6 expect" : "R5 expect", {31'b0, reqExpectResp}, {31'b0, isRd});
      chk(isRd ? "R6 no payload" : "R5 payload", reqData, isRd ? 32'h0 : pay);
      for (int d = 0; d < i % 3; d++) begin
        @(negedge clk);
        chk("R4 held valid", {31'b0, reqValid}, 32'h1);
        chk("R4 held fields", {reqOpcode, reqPort, reqOffset, reqByteEn, 4'h0}, word);
      end
      handshake();
      chk("R4 drop after accept", {31'b0, reqValid}, 32'h0);
      if (isRd) begin
        cfgRead(A_STAT, rd); chk("R6 busy waits", rd, 32'h1);
        respond(rsp);
        cfgRead(A_DATA, rd);
        chk("R6 merge", rd, (pay & ~beMask(be)) | (rsp & beMask(be)));
      end
      cfgRead(A_STAT, rd); chk(isRd ? "R6 done" : "R5 done", rd, 32'h0);
    end

    // R8 / R9: refused command and data writes while busy
    cfgWrite(A_DATA, 32'hCAFEF00D, 4'hF);
    cfgWrite(A_CMD, 32'h07123450, 4'hF);
    cfgWrite(A_CMD, 32'h06998870, 4'hF);
    chk("R8 ignored cmd", {24'b0, reqOpcode}, 32'h07);
    chk("R8 ignored port", {24'b0, reqPort}, 32'h12);
    cfgWrite(A_DATA, 32'h12345678, 4'hF);
    cfgRead(A_DATA, rd); chk("R9 busy write blocked", rd, 32'hCAFEF00D);
    chk("R9 payload intact", reqData, 32'hCAFEF00D);
    cfgRead(A_STAT, rd); chk("R8 overrun set", rd, 32'h3);
    @(negedge clk);
    handshake();
    chk("R8 single request", {31'b0, reqValid}, 32'h0);
    cfgRead(A_STAT, rd); chk("R8 sticky", rd, 32'h2);
    cfgWrite(A_STAT, 32'h1, 4'hF);
    cfgRead(A_STAT, rd); chk("R8 bit1 clear keeps", rd, 32'h2);
    cfgWrite(A_STAT, 32'h2, 4'hE);
    cfgRead(A_STAT, rd); chk("R8 byte0 disabled keeps", rd, 32'h2);
    cfgWrite(A_STAT, 32'h2, 4'h1);
    cfgRead(A_STAT, rd); chk("R8 w1c", rd, 32'h0);

    // R10 stray responses
    respond(32'hDEADBEEF);
    cfgRead(A_DATA, rd); chk("R10 idle rsp ignored", rd, 32'hCAFEF00D);
    cfgWrite(A_CMD, 32'h10010200 | 32'h000000F0, 4'hF);
    respond(32'h0BADF00D);
    chk("R10 send rsp ignored valid", {31'b0, reqValid}, 32'h1);
    cfgRead(A_DATA, rd); chk("R10 send rsp ignored data", rd, 32'hCAFEF00D);
    @(negedge clk);
    handshake();
    cfgRead(A_STAT, rd); chk("R10 still waiting", rd, 32'h1);
    respond(32'h55AA33CC);
    cfgRead(A_DATA, rd); chk("R6 full load", rd, 32'h55AA33CC);
    cfgRead(A_CMD, rd); chk("R7 cmd read zero", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule